// File: doc/BRIEF.md
# Cascadable Reload Timer Bank

A bank of four 8-bit down-counting timers sharing one byte-addressed register port. Each timer holds a control byte, a reload byte and a running count. A timer that is enabled steps down once per tick of its chosen source. The tick that finds the count at zero makes the timer reload from its reload byte and raise its own underflow output for one cycle. The source is either every cycle of the block clock or the underflow pulse of the next lower-numbered timer, so two or more timers chain into a wider counter.

Software reaches the timers through a single request port. Writes are one byte wide. Reads are one, two or four bytes wide, and a wide read packs the registers of neighbouring timers with the lower-numbered timer in the higher byte. Any access the map does not allow sets a sticky error flag and returns zero. Read data is registered and appears one cycle after the request.

Top module: `tmr_bank`

## Requirements
- R1: After reset all control bytes, reload bytes and counts are zero, `err_o` is 0, `uflow_o` is all zero and `rdata_o` is zero.
- R2: A one-byte write (size 0) to offset 0x00+i sets the control byte of timer i, and one to 0x10+i sets its reload byte (i = 0..3). A one-byte read at the same offset returns the stored value in `rdata_o[7:0]`. A one-byte read at 0x20+i returns the count view of timer i.
- R3: Control bit 6 is a load request. On the next clock edge it copies the reload byte into the count and then clears itself, so it reads back as 0. While it is pending it takes priority over counting and produces no underflow.
- R4: Control bit 7 enables counting. With clock select bits [1:0] = 00 the count decrements on every edge, starting with the edge that follows the write that set bit 7. Select codes 01 and 10 never tick, and a disabled timer holds its count.
- R5: A tick that finds the count at zero reloads the count from the reload byte and drives that timer's `uflow_o` bit high for exactly the following cycle.
- R6: With clock select 11, timer i (i > 0) ticks once for each cycle that `uflow_o[i-1]` is high. Timer 0 with select 11 never ticks.
- R7: Writing the reload byte of a running timer leaves the current count untouched. The new value is first used at the next reload.
- R8: While bit 7 of its control byte is 0, a read of a timer's count returns its reload byte.
- R9: A two-byte read (size 1) at timer index 0 or 2 returns that timer's register in bits [15:8] and the next timer's register in bits [7:0], with bits [31:16] zero.
- R10: A four-byte read (size 2) at timer index 0 returns timers 0, 1, 2 and 3 in bits [31:24], [23:16], [15:8] and [7:0].
- R11: Each of the following sets `err_o`, which stays set until reset, and changes no register; a failing read also returns zero: a two-byte read at index 1 or 3, a four-byte read at a nonzero index, size code 3, an offset outside the three register groups or with index above 3, and any write wider than one byte or aimed at the count group.
- R12: `rdata_o` takes the read result on the edge that samples the read request and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the base tick source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset: [5:4] group (0 control, 1 reload, 2 count), [3:0] timer index |
| size_i | input | 2 | Access size: 0 = one byte, 1 = two bytes, 2 = four bytes, 3 = illegal |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Sticky illegal-access flag |
| uflow_o | output | 4 | Per-timer one-cycle underflow pulse |

## Verification
A wrong count, reload value or tick source inside a timer shows up at `uflow_o` within one timer period, as a pulse in the wrong cycle, and in a cascaded pair it also shifts the downstream pulse train. A bad decode or lane merge shows up in `rdata_o` in the cycle after the read that touches the faulty lane. A missed error condition shows up as `err_o` failing to rise in the cycle after the bad access. The reference model tracks every timer on every edge, so any divergence is reported in the cycle it first becomes visible at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned MD_EN = 7;
  localparam int unsigned MD_LD = 6;
  localparam logic [1:0] CS_IOCLK = 2'b00;
  localparam logic [1:0] CS_CASC  = 2'b11;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_MODE = 2'd0,
    RG_BASE = 2'd1,
    RG_CNT  = 2'd2,
    RG_NONE = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit HAS_PREV = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic          base_we_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          casc_i,
  output logic [BW-1:0] mode_o,
  output logic [BW-1:0] base_o,
  output logic [BW-1:0] view_o,
  output logic          uflow_o
);
  logic [BW-1:0] mode_q, base_q, cnt_q;
  logic          uflow_q;
  logic          en, ld, tick, zero;

  assign en   = mode_q[MD_EN];
  assign ld   = mode_q[MD_LD];
  assign zero = (cnt_q == '0);

  always_comb begin
    case (mode_q[1:0])
      CS_IOCLK: tick = 1'b1;
      CS_CASC:  tick = HAS_PREV & casc_i;
      default:  tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wdata_i;
    else if (ld)        mode_q[MD_LD] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= wdata_i;
  end

  // load wins over counting; underflow reloads from the live base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= 1'b0;
      if (ld) begin
        cnt_q <= base_q;
      end else if (en && tick) begin
        if (zero) begin
          cnt_q   <= base_q;
          uflow_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign mode_o  = mode_q;
  assign base_o  = base_q;
  assign view_o  = en ? cnt_q : base_q;
  assign uflow_o = uflow_q;

  assert_load_copies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (cnt_q == $past(base_q)));
  assert_load_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld && !mode_we_i) |=> !mode_q[MD_LD]);
  assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ld) |=> $stable(cnt_q));
  assert_step_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !ld && tick && !zero) |=> (cnt_q == ($past(cnt_q) - {{(BW-1){1'b0}}, 1'b1})));
  assert_uflow_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |-> (cnt_q == $past(base_q)));
  assert_no_uflow_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en || ld || !tick) |=> !uflow_o);
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned NT = 4,
  parameter int unsigned AW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [1:0]             size_i,
  input  logic [NT-1:0][BW-1:0]  mode_i,
  input  logic [NT-1:0][BW-1:0]  base_i,
  input  logic [NT-1:0][BW-1:0]  view_i,
  output logic [NT-1:0]          mode_we_o,
  output logic [NT-1:0]          base_we_o,
  output logic [DW-1:0]          rdata_o,
  output logic                   err_o
);
  localparam int unsigned IW    = $clog2(NT);
  localparam int unsigned LANES = DW / BW;

  reg_grp_e              grp;
  logic [3:0]            idx;
  logic [IW-1:0]         lidx, nidx;
  logic                  mapped, size_ok, rd_ok, wr_ok;
  logic [NT-1:0][BW-1:0] sel;
  logic [DW-1:0]         rd_val, rdata_q;
  logic                  err_q;

  assign grp    = reg_grp_e'(addr_i[5:4]);
  assign idx    = addr_i[3:0];
  assign lidx   = idx[IW-1:0];
  assign nidx   = lidx + 1'b1;
  assign mapped = (addr_i[AW-1:6] == '0) && (grp != RG_NONE) && (idx < 4'(NT));

  always_comb begin
    case (grp)
      RG_MODE: sel = mode_i;
      RG_BASE: sel = base_i;
      default: sel = view_i;
    endcase
  end

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_B1:   size_ok = 1'b1;
      SZ_B2:   size_ok = !idx[0] && ((idx + 4'd1) < 4'(NT));
      SZ_B4:   size_ok = (idx == '0);
      default: size_ok = 1'b0;
    endcase
  end

  assign rd_ok = mapped && size_ok;
  assign wr_ok = mapped && (acc_size_e'(size_i) == SZ_B1) && (grp != RG_CNT);

  // lower-numbered timer lands in the more significant byte
  always_comb begin
    rd_val = '0;
    case (acc_size_e'(size_i))
      SZ_B1: rd_val[BW-1:0] = sel[lidx];
      SZ_B2: rd_val[2*BW-1:0] = {sel[lidx], sel[nidx]};
      default: begin
        for (int k = 0; k < LANES; k++) rd_val[DW-1-k*BW -: BW] = sel[k];
      end
    endcase
  end

  for (genvar g = 0; g < NT; g++) begin : g_we
    assign mode_we_o[g] = req_i && we_i && wr_ok && (grp == RG_MODE) && (lidx == IW'(g));
    assign base_we_o[g] = req_i && we_i && wr_ok && (grp == RG_BASE) && (lidx == IW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (req_i) begin
      if (!we_i) rdata_q <= rd_ok ? rd_val : '0;
      if (we_i ? !wr_ok : !rd_ok) err_q <= 1'b1;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  assert_single_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mode_we_o, base_we_o}));
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_bad_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !rd_ok) |=> (rdata_o == '0) && err_o);
  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NT = 4,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [BW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic [NT-1:0] uflow_o
);
  logic [NT-1:0][BW-1:0] mode, base, view;
  logic [NT-1:0]         mode_we, base_we, casc, uf;

  tmr_regif #(.NT(NT), .AW(AW)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .mode_i    (mode),
    .base_i    (base),
    .view_i    (view),
    .mode_we_o (mode_we),
    .base_we_o (base_we),
    .rdata_o   (rdata_o),
    .err_o     (err_o)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    if (g == 0) begin : g_head
      assign casc[g] = 1'b0;
    end else begin : g_chain
      assign casc[g] = uf[g-1];
    end
    tmr_unit #(.HAS_PREV(g != 0)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_we_i (mode_we[g]),
      .base_we_i (base_we[g]),
      .wdata_i   (wdata_i),
      .casc_i    (casc[g]),
      .mode_o    (mode[g]),
      .base_o    (base[g]),
      .view_o    (view[g]),
      .uflow_o   (uf[g])
    );
  end

  assign uflow_o = uf;
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [3:0]  uflow_o;

  int checks = 0, bad = 0, cyc = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;

  always #4 clk = ~clk;

  tmr_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .uflow_o(uflow_o)
  );

  // reference model
  logic [7:0] m_mode[4], m_base[4], m_cnt[4], o_mode[4], o_base[4], o_cnt[4];
  bit         m_uf[4], o_uf[4];
  logic [31:0] m_rd;
  bit          m_err;

  function automatic logic [7:0] mview(int grp, int i);
    if (grp == 0) return o_mode[i];
    if (grp == 1) return o_base[i];
    return o_mode[i][7] ? o_cnt[i] : o_base[i];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin
        m_mode[i] = 0; m_base[i] = 0; m_cnt[i] = 0; m_uf[i] = 0;
      end
      m_rd = 0; m_err = 0;
    end else begin
      int grp, ix;
      bit mapped;
      for (int i = 0; i < 4; i++) begin
        o_mode[i] = m_mode[i]; o_base[i] = m_base[i]; o_cnt[i] = m_cnt[i]; o_uf[i] = m_uf[i];
      end
      for (int i = 0; i < 4; i++) begin
        bit tk;
        tk = (o_mode[i][1:0] == 2'b00) || (o_mode[i][1:0] == 2'b11 && i > 0 && o_uf[i-1]);
        m_uf[i] = 0;
        if (o_mode[i][6]) begin
          m_cnt[i] = o_base[i]; m_mode[i][6] = 1'b0;
        end else if (o_mode[i][7] && tk) begin
          if (o_cnt[i] == 0) begin m_cnt[i] = o_base[i]; m_uf[i] = 1; end
          else m_cnt[i] = o_cnt[i] - 8'd1;
        end
      end
      if (req_i) begin
        grp = int'(addr_i[5:4]); ix = int'(addr_i[3:0]);
        mapped = (addr_i[7:6] == 0) && grp < 3 && ix < 4;
        if (we_i) begin
          if (mapped && size_i == 0 && grp != 2) begin
            if (grp == 0) m_mode[ix] = wdata_i; else m_base[ix] = wdata_i;
          end else m_err = 1;
        end else begin
          if (mapped && size_i == 0)
            m_rd = {24'd0, mview(grp, ix)};
          else if (mapped && size_i == 1 && (ix == 0 || ix == 2))
            m_rd = {16'd0, mview(grp, ix), mview(grp, ix + 1)};
          else if (mapped && size_i == 2 && ix == 0)
            m_rd = {mview(grp, 0), mview(grp, 1), mview(grp, 2), mview(grp, 3)};
          else begin m_rd = 0; m_err = 1; end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (uflow_o[i] !== m_uf[i]) begin
          bad++;
          $display("FAIL %s/R5 cyc %0d uflow[%0d] act=%0b exp=%0b", phase, cyc, i, uflow_o[i], m_uf[i]);
        end
      end
      checks++;
      if (rdata_o !== m_rd) begin
        bad++;
        $display("FAIL %s/R12 cyc %0d rdata act=%h exp=%h", phase, cyc, rdata_o, m_rd);
      end
      checks++;
      if (err_o !== m_err) begin
        bad++;
        $display("FAIL %s/R11 cyc %0d err act=%0b exp=%0b", phase, cyc, err_o, m_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic [1:0] sz = 2'd0);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; size_i = sz;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a; size_i = sz;
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, d2;
    int c1;
    idle(3);
    rst_ni = 1;
    cmp_on = 1;
    phase = "R1";
    chk("R1 rdata after reset", rdata_o, 0);
    chk("R1 err after reset", {31'd0, err_o}, 0);
    chk("R1 uflow after reset", {28'd0, uflow_o}, 0);
    rd(8'h00, 2'd2, d); chk("R1 control bytes zero", d, 0);
    rd(8'h10, 2'd2, d); chk("R1 reload bytes zero", d, 0);

    phase = "R2";
    wr(8'h10, 8'h05); wr(8'h11, 8'h03); wr(8'h12, 8'hA5); wr(8'h13, 8'h3C);
    rd(8'h12, 2'd0, d); chk("R2 reload byte readback", d, 32'hA5);
    phase = "R9";
    rd(8'h10, 2'd1, d); chk("R9 pair at index 0", d, 32'h0503);
    rd(8'h12, 2'd1, d); chk("R9 pair at index 2", d, 32'hA53C);
    phase = "R10";
    rd(8'h10, 2'd2, d); chk("R10 packed reload bytes", d, 32'h0503A53C);
    phase = "R8";
    rd(8'h20, 2'd0, d); chk("R8 stopped count shows reload", d, 32'h05);
    rd(8'h20, 2'd2, d); chk("R8 stopped counts packed", d, 32'h0503A53C);

    phase = "R3";
    wr(8'h03, 8'h40); idle(2);
    rd(8'h03, 2'd0, d); chk("R3 load bit self-clears", d, 0);
    phase = "R4";
    wr(8'h03, 8'h80);
    rd(8'h23, 2'd0, d); chk("R4 first decrement after enable", d, 32'h3B);
    wr(8'h03, 8'h00);
    wr(8'h02, 8'hC1); idle(3);
    rd(8'h22, 2'd0, d); idle(10);
    rd(8'h22, 2'd0, d2);
    chk("R4 select 01 holds count", d, 32'hA5);
    chk("R4 select 01 holds count later", d2, 32'hA5);

    phase = "R5";
    wr(8'h00, 8'hC0); idle(40);
    rd(8'h00, 2'd0, d); chk("R3 control reads without load bit", d, 32'h80);
    phase = "R6";
    wr(8'h01, 8'hC3);
    c1 = 0;
    for (int k = 0; k < 240; k++) begin
      @(negedge clk);
      if (uflow_o[1]) c1++;
    end
    checks++;
    if (c1 < 9 || c1 > 11) begin
      bad++;
      $display("FAIL R6 cascade pulses act=%0d exp=9..11", c1);
    end
    rd(8'h20, 2'd1, d);
    phase = "R7";
    wr(8'h10, 8'h02); idle(30);
    rd(8'h10, 2'd0, d); chk("R7 reload byte updated", d, 32'h02);
    rd(8'h20, 2'd0, d);

    phase = "R6";
    wr(8'h00, 8'h83); idle(2);
    rd(8'h20, 2'd0, d); idle(20);
    rd(8'h20, 2'd0, d2);
    chk("R6 timer 0 cascade frozen", d2, d);

    phase = "R11";
    chk("R11 err clear before bad access", {31'd0, err_o}, 0);
    rd(8'h11, 2'd1, d); chk("R11 pair at index 1 reads zero", d, 0);
    chk("R11 err set", {31'd0, err_o}, 1);
    rd(8'h30, 2'd0, d); chk("R11 unmapped group reads zero", d, 0);
    rd(8'h12, 2'd2, d); chk("R11 quad at index 2 reads zero", d, 0);
    wr(8'h11, 8'h77, 2'd1);
    wr(8'h21, 8'h77);
    rd(8'h11, 2'd0, d); chk("R11 rejected writes leave reload", d, 32'h03);
    chk("R11 err still set", {31'd0, err_o}, 1);
    idle(5);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule